// File: doc/BRIEF.md
# Indirect Register Window

This block gives a processor access to a large bank of interrupt-control registers through just two fixed addresses. The first address holds an index register, which software writes to choose a target. The second address is a window. A read or write through the window reaches whichever internal register the current index selects. The index keeps its value after a window access, so software can make several window accesses to the same target without rewriting it.

The storage behind the window has five parts:
- sixteen priority words;
- a one-bit delivery enable;
- an eight-bit threshold;
- sixty-four pending words;
- sixty-four enable words.

Some index values are reserved. They always read as zero, and writes to them are dropped without any error. Every other index value has no target behind it. A window access with such an index raises an illegal flag and changes nothing. Each access is a single cycle on one request port, with read data and the flag returned one cycle later.

Top module: `irw_window`

## Requirements
- R1: A write with `acc_alias`=0 stores the low 12 bits of `acc_wdata` into the index register. A read with `acc_alias`=0 returns that index, zero-extended. The index holds its value until it is written again.
- R2: Index values 0x030 to 0x03F (0x030+k) reach priority word k. All 32 bits can be written and read back.
- R3: Index value 0x070 reaches the delivery-enable register. Only bit 0 is stored, and bits 31:1 read as zero.
- R4: Index value 0x072 reaches the threshold register. Only bits 7:0 are stored, and bits 31:8 read as zero.
- R5: Index values 0x071 and 0x073 to 0x07F read as zero. Writes to them are ignored, and the illegal flag stays low.
- R6: Index value 0x080+k reaches pending word k, and 0x0C0+k reaches enable word k, for k from 0 to 63. All 32 bits are stored.
- R7: Any other index value, including every value of 0x100 or above, is unmapped. A window access with an unmapped index has these effects:
  - `illegal` is high in the cycle after the access;
  - a read returns zero;
  - no stored register changes.
- R8: `rd_data` takes its new value in the cycle after a read access and holds it through every other cycle. `illegal` is high only in the single cycle after an unmapped window access.
- R9: Reset clears the index register, every stored register, `rd_data` and `illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_alias | input | 1 | 1 = window access, 0 = index register access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read result, registered |
| illegal | output | 1 | Pulses for one cycle after an unmapped window access |

## Verification
The assertions check several properties on every cycle:
- an unmapped window access, and nothing else, causes the flag pulse;
- such an access drives no storage write strobe;
- at most one write strobe is active at a time;
- read data holds still when no read occurs;
- reads of the delivery, threshold and reserved indices carry no bits outside their stored width.

Only the bench's sweeps can show that each mapped index reaches its own distinct storage word and that no two indices alias one another. The bench writes every index from 0x000 to 0x1FF and then reads all of them back a second time. That second read-back also shows that writes to unmapped and reserved indices left every stored value intact.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int SEL_W = 12;
  localparam int IDX_W = 6;

  typedef enum logic [2:0] {
    RG_NONE, RG_PRIO, RG_DELIV, RG_THRESH, RG_ZERO, RG_PEND, RG_ENAB
  } region_e;

  typedef struct packed {
    region_e            rg;
    logic [IDX_W-1:0]   idx;
  } target_t;

  // Map an index value onto a storage region and word offset.
  function automatic target_t decode_sel(input logic [SEL_W-1:0] s);
    target_t t;
    t.rg  = RG_NONE;
    t.idx = s[IDX_W-1:0];
    if (s[SEL_W-1:8] == '0) begin
      if (s[7:4] == 4'h3)                       t.rg = RG_PRIO;
      else if (s[7:0] == 8'h70)                 t.rg = RG_DELIV;
      else if (s[7:0] == 8'h72)                 t.rg = RG_THRESH;
      else if (s[7:4] == 4'h7)                  t.rg = RG_ZERO;
      else if (s[7:6] == 2'b10)                 t.rg = RG_PEND;
      else if (s[7:6] == 2'b11)                 t.rg = RG_ENAB;
    end
    return t;
  endfunction

  // Low-bit keep mask for narrow registers.
  function automatic logic [31:0] keep_mask(input int unsigned bits);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < bits);
    return m;
  endfunction
endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output target_t          tgt
);
  always_comb tgt = decode_sel(sel);
endmodule

// File: rtl/irw_bank.sv
module irw_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/irw_scalar.sv
module irw_scalar #(
  parameter int DW     = 32,
  parameter int KEEP_W = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam logic [31:0] MASK = irw_pkg::keep_mask(KEEP_W);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & MASK[DW-1:0];
  end
endmodule

// File: rtl/irw_window.sv
module irw_window
  import irw_pkg::*;
#(
  parameter int DW      = 32,
  parameter int N_PRIO  = 16,
  parameter int N_WORDS = 64,
  parameter int THR_W   = 8,
  parameter int DEL_W   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_alias,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          illegal
);
  localparam int PRIO_AW = $clog2(N_PRIO);
  localparam int WORD_AW = $clog2(N_WORDS);

  logic [SEL_W-1:0] sel_q;
  target_t          tgt;

  // Named events for the checker
  logic alias_acc, sel_acc, alias_rd, unmapped_acc;
  logic wr_sel, wr_prio, wr_deliv, wr_thr;
  logic [1:0] wr_word;
  logic [5:0] we_vec;

  irw_decode u_dec (.sel(sel_q), .tgt(tgt));

  assign alias_acc    = acc_valid &  acc_alias;
  assign sel_acc      = acc_valid & ~acc_alias;
  assign alias_rd     = alias_acc & ~acc_write;
  assign unmapped_acc = alias_acc & (tgt.rg == RG_NONE);
  assign wr_sel       = sel_acc & acc_write;
  assign wr_prio      = alias_acc & acc_write & (tgt.rg == RG_PRIO);
  assign wr_deliv     = alias_acc & acc_write & (tgt.rg == RG_DELIV);
  assign wr_thr       = alias_acc & acc_write & (tgt.rg == RG_THRESH);
  assign wr_word[0]   = alias_acc & acc_write & (tgt.rg == RG_PEND);
  assign wr_word[1]   = alias_acc & acc_write & (tgt.rg == RG_ENAB);
  assign we_vec       = {wr_sel, wr_prio, wr_deliv, wr_thr, wr_word};

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= acc_wdata[SEL_W-1:0];
  end

  logic [DW-1:0] prio_rd, deliv_q, thr_q;
  logic [DW-1:0] word_rd [2];

  irw_bank #(.DEPTH(N_PRIO), .DW(DW)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(wr_prio), .idx(tgt.idx[PRIO_AW-1:0]),
    .wdata(acc_wdata), .rdata(prio_rd)
  );

  // Pending (0) and enable (1) word files share one shape.
  for (genvar g = 0; g < 2; g++) begin : g_words
    irw_bank #(.DEPTH(N_WORDS), .DW(DW)) u_words (
      .clk(clk), .rst_n(rst_n), .we(wr_word[g]), .idx(tgt.idx[WORD_AW-1:0]),
      .wdata(acc_wdata), .rdata(word_rd[g])
    );
  end

  irw_scalar #(.DW(DW), .KEEP_W(DEL_W)) u_deliv (
    .clk(clk), .rst_n(rst_n), .we(wr_deliv), .wdata(acc_wdata), .q(deliv_q)
  );
  irw_scalar #(.DW(DW), .KEEP_W(THR_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .we(wr_thr), .wdata(acc_wdata), .q(thr_q)
  );

  logic [DW-1:0] alias_rdata, next_rd;
  always_comb begin
    unique case (tgt.rg)
      RG_PRIO:   alias_rdata = prio_rd;
      RG_DELIV:  alias_rdata = deliv_q;
      RG_THRESH: alias_rdata = thr_q;
      RG_PEND:   alias_rdata = word_rd[0];
      RG_ENAB:   alias_rdata = word_rd[1];
      default:   alias_rdata = '0;
    endcase
    next_rd = acc_alias ? alias_rdata : {{(DW-SEL_W){1'b0}}, sel_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= unmapped_acc;
      if (acc_valid && !acc_write) rd_data <= next_rd;
    end
  end
endmodule

// File: rtl/irw_window_chk.sv
module irw_window_chk
  import irw_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          alias_rd,
  input region_e       rg,
  input logic          unmapped_acc,
  input logic [5:0]    we_vec,
  input logic          illegal,
  input logic [DW-1:0] rd_data
);
  // R7
  unmapped_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_acc |=> illegal);
  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(unmapped_acc));
  // R7
  no_write_on_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_acc |-> (we_vec == '0));
  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> $stable(rd_data));
  // R5
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_rd && rg == RG_ZERO) |=> rd_data == '0);
  // R3
  deliv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_rd && rg == RG_DELIV) |=> rd_data[DW-1:1] == '0);
  // R4
  thr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_rd && rg == RG_THRESH) |=> rd_data[DW-1:8] == '0);
endmodule

bind irw_window irw_window_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .alias_rd(alias_rd), .rg(tgt.rg), .unmapped_acc(unmapped_acc),
  .we_vec(we_vec), .illegal(illegal), .rd_data(rd_data)
);

// File: tb/sim_irw_window.sv
module sim_irw_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_alias = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        illegal;

  int checks = 0, fails = 0;
  logic [31:0] m_prio [16];
  logic [31:0] m_pend [64];
  logic [31:0] m_enab [64];
  logic [31:0] m_del, m_thr, last_rd;

  always #10 clk = ~clk;

  irw_window u0 (.*);

  // 0 none, 1 prio, 2 deliv, 3 thr, 4 zero, 5 pend, 6 enab
  function automatic int region(int s);
    if (s >= 'h30 && s <= 'h3F) return 1;
    if (s == 'h70) return 2;
    if (s == 'h72) return 3;
    if (s >= 'h71 && s <= 'h7F) return 4;
    if (s >= 'h80 && s <= 'hBF) return 5;
    if (s >= 'hC0 && s <= 'hFF) return 6;
    return 0;
  endfunction

  function automatic logic [31:0] pat(int s, int pass);
    return (32'(s) * 32'h9E3779B1) ^ (pass ? 32'h13579BDF : 32'hDEADBEEF);
  endfunction

  function automatic logic [31:0] expect_rd(int s);
    case (region(s))
      1: return m_prio[s - 'h30];
      2: return m_del;
      3: return m_thr;
      5: return m_pend[s - 'h80];
      6: return m_enab[s - 'hC0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(bit al, bit wr, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_alias = al; acc_write = wr; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
  endtask

  task automatic model_write(int s, logic [31:0] d);
    case (region(s))
      1: m_prio[s - 'h30] = d;
      2: m_del = d & 32'h1;
      3: m_thr = d & 32'hFF;
      5: m_pend[s - 'h80] = d;
      6: m_enab[s - 'hC0] = d;
      default: ;
    endcase
  endtask

  task automatic clear_model();
    for (int i = 0; i < 16; i++) m_prio[i] = '0;
    for (int i = 0; i < 64; i++) begin m_pend[i] = '0; m_enab[i] = '0; end
    m_del = '0; m_thr = '0; last_rd = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 rd_data", rd_data, 32'h0);
    chk("R9 illegal", {31'h0, illegal}, 32'h0);
    acc(0, 0, 0);
    chk("R9 index", rd_data, 32'h0);

    // R1 only low 12 bits kept
    acc(0, 1, 32'hFFFF_F0C5);
    acc(0, 0, 0);
    chk("R1 truncation", rd_data, 32'h0C5);
    last_rd = rd_data;

    for (int pass = 0; pass < 2; pass++) begin
      for (int s = 0; s < 'h200; s++) begin
        bit bad;
        bad = (region(s) == 0);
        acc(0, 1, 32'(s));
        chk("R8 hold after index write", rd_data, last_rd);
        acc(0, 0, 0);
        chk("R1 index readback", rd_data, 32'(s));
        acc(1, 1, pat(s, pass));
        chk("R7 flag on write", {31'h0, illegal}, {31'h0, bad});
        chk("R8 hold after window write", rd_data, 32'(s));
        model_write(s, pat(s, pass));
        @(negedge clk);
        chk("R8 flag one cycle", {31'h0, illegal}, 32'h0);
        acc(1, 0, 0);
        // R2 R3 R4 R5 R6 R7 read values
        chk($sformatf("R2-6 read sel %h", s), rd_data, expect_rd(s));
        chk("R7 flag on read", {31'h0, illegal}, {31'h0, bad});
        last_rd = rd_data;
      end
      // Re-read everything: no aliasing, ignored writes left state intact
      for (int s = 0; s < 'h200; s++) begin
        acc(0, 1, 32'(s));
        acc(1, 0, 0);
        chk($sformatf("R6 R7 reread sel %h", s), rd_data, expect_rd(s));
        last_rd = rd_data;
      end
    end

    // R1 index persists across window accesses
    acc(0, 1, 32'h3A);
    acc(1, 1, 32'hCAFE_0001);
    acc(1, 1, 32'hCAFE_0002);
    acc(0, 0, 0);
    chk("R1 persistence", rd_data, 32'h3A);
    acc(1, 0, 0);
    chk("R2 last write wins", rd_data, 32'hCAFE_0002);

    // R9 reset clears storage
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 rd after reset", rd_data, 32'h0);
    acc(0, 0, 0);
    chk("R9 index after reset", rd_data, 32'h0);
    acc(0, 1, 32'h8A);
    acc(1, 0, 0);
    chk("R9 pending cleared", rd_data, 32'h0);
    acc(0, 1, 32'h70);
    acc(1, 0, 0);
    chk("R9 delivery cleared", rd_data, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule